// File: doc/BRIEF.md
# Two-Vector Scan Launcher with Hold Stages

This block applies a delay test to a piece of combinational logic through a scan chain whose flops do not drive the logic directly. Each scan flop feeds a hold register. All hold registers load together when a single update strobe is raised. The logic under test sees only the hold registers, so its inputs stay frozen while bits ripple through the chain. Because of this, the launch vector is not tied to the initialising vector, and any two words can be used as the pair.

A built-in sequencer runs the whole test after one start pulse, using the two vectors offered as parallel words. The steps are:
1. Serialise the first word into the chain, then raise the update strobe to apply it.
2. Serialise the second word into the chain, then raise the update strobe again. This second strobe launches the transition.
3. On the very next clock, load the logic's response into the chain through the flops' functional inputs.
4. Shift the response out serially, one bit per cycle.
5. Present the reassembled word in parallel, together with a one-cycle done pulse.

Top module: `hold_scan_top`

## Requirements
- R1: After synchronous reset, the drive bus, the serial output, the done flag and the parallel response are all zero.
- R2: A start pulse seen while idle captures both vector words. A start pulse during a run has no effect on that run: the bus values, the unloaded bits and the response are those of the vectors taken at the accepted start.
- R3: The drive bus never changes on a clock edge that ends a shift cycle. It changes only on the two update edges of a run, and it keeps its last value after the run ends.
- R4: Take the edge that accepts start as edge 0, and let W be the chain length. The drive bus shows the first vector from edge W+1 on.
- R5: The drive bus shows the second vector from edge 2W+2 on. This holds for any pair of vectors, including two equal words and two complementary words.
- R6: The response bus is captured at edge 2W+3, exactly one clock after the launching update. The captured word is whatever the logic presents during that single cycle.
- R7: After edge 2W+3+k, the serial output carries bit W-1-k of the captured word, for k = 0 to W-1. The most significant bit comes out first.
- R8: After edge 3W+3, done is high for one cycle only, and the parallel response equals the captured word. That word stays on the response output until the next run starts unloading.
- R9: If the logic has a slow output bit, that bit still shows its value for the first vector during the capture cycle. The captured word then differs from the fault-free response to the second vector in that bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the chain, the hold stages and the sequencer |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins a test; honoured only when idle |
| vec_a_i | input | W | Initialising vector, applied by the first update |
| vec_b_i | input | W | Launch vector, applied by the second update |
| drive_o | output | W | Hold-stage outputs that feed the logic under test |
| resp_i | input | W | Response of the logic under test |
| scan_out_o | output | 1 | Serial chain output; carries the captured word during unload |
| resp_o | output | W | Captured word, reassembled from the unloaded bits |
| done_o | output | 1 | One-cycle pulse when resp_o holds a new result |

## Verification
The hardest case to reach from the ports is a transition fault seen during the single capture cycle. A fault is only visible when the faulty bit differs between the responses to the two vectors, and only if capture lands exactly one cycle after the launch. The bench sets this up with a behavioural model of the logic that can hold one output bit at its previous-cycle value. It picks the faulty bit from the bits where the responses to the first and second vector differ, so the fault is actually excited. A start pulse injected in the middle of a run, and pairs of equal or complementary vectors, show that the two words stay independent and that the sequencer holds the vectors it accepted.

// File: rtl/hscan_pkg.sv
`timescale 1ns/1ps
package hscan_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_LOAD_A,
        PH_APPLY_A,
        PH_LOAD_B,
        PH_LAUNCH,
        PH_CAPTURE,
        PH_UNLOAD,
        PH_DONE
    } phase_e;

    typedef struct packed {
        logic shift;
        logic update;
        logic capture;
    } chain_cmd_t;

    function automatic logic phase_shifts(phase_e p);
        return (p == PH_LOAD_A) || (p == PH_LOAD_B) || (p == PH_UNLOAD);
    endfunction

    function automatic logic phase_updates(phase_e p);
        return (p == PH_APPLY_A) || (p == PH_LAUNCH);
    endfunction

endpackage

// File: rtl/hscan_chain.sv
`timescale 1ns/1ps
module hscan_chain
    import hscan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  chain_cmd_t   cmd,
    input  logic         si,
    input  logic [W-1:0] func_d,
    output logic [W-1:0] q,
    output logic         so
);
    logic [W-1:0] cells;

    always_ff @(posedge clk) begin
        if (rst) begin
            cells <= '0;
        end else if (cmd.capture) begin
            cells <= func_d;
        end else if (cmd.shift) begin
            cells <= {cells[W-2:0], si};
        end
    end

    assign q  = cells;
    assign so = cells[W-1];

    // R7: unload shifting moves the tail bit towards the serial output
    assert_shift_moves_R7: assert property (@(posedge clk) disable iff (rst)
        cmd.shift && !cmd.capture |=> so == $past(cells[W-2]));
endmodule

// File: rtl/hscan_hold.sv
`timescale 1ns/1ps
module hscan_hold
    import hscan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         upd,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_stage
        logic stage_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q <= 1'b0;
            end else if (upd) begin
                stage_q <= d[i];
            end
        end
        assign q[i] = stage_q;
    end
endmodule

// File: rtl/hscan_ctrl.sv
`timescale 1ns/1ps
module hscan_ctrl
    import hscan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [W-1:0] vec_a,
    input  logic [W-1:0] vec_b,
    input  logic         so_i,
    output chain_cmd_t   cmd,
    output logic         si_o,
    output logic [W-1:0] resp_q,
    output logic         done
);
    localparam int CW = (W > 2) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic [W-1:0]  src;
    logic [W-1:0]  pend;
    logic          last;

    assign last = (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            src    <= '0;
            pend   <= '0;
            resp_q <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        src   <= vec_a;
                        pend  <= vec_b;
                        cnt   <= '0;
                        phase <= PH_LOAD_A;
                    end
                end
                PH_LOAD_A, PH_LOAD_B: begin
                    src <= {src[W-2:0], 1'b0};
                    cnt <= cnt + 1'b1;
                    if (last) begin
                        cnt   <= '0;
                        phase <= (phase == PH_LOAD_A) ? PH_APPLY_A : PH_LAUNCH;
                    end
                end
                PH_APPLY_A: begin
                    src   <= pend;
                    phase <= PH_LOAD_B;
                end
                PH_LAUNCH:  phase <= PH_CAPTURE;
                PH_CAPTURE: begin
                    cnt   <= '0;
                    phase <= PH_UNLOAD;
                end
                PH_UNLOAD: begin
                    resp_q <= {resp_q[W-2:0], so_i};
                    cnt    <= cnt + 1'b1;
                    if (last) begin
                        cnt   <= '0;
                        phase <= PH_DONE;
                    end
                end
                PH_DONE: phase <= PH_IDLE;
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd.shift   = phase_shifts(phase);
        cmd.update  = phase_updates(phase);
        cmd.capture = (phase == PH_CAPTURE);
    end

    assign si_o = src[W-1];
    assign done = (phase == PH_DONE);

    // R3: shift, update and capture never overlap
    assert_cmd_exclusive_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd.shift, cmd.update, cmd.capture}));

    // R6: capture always follows an update by exactly one cycle
    assert_capture_after_launch_R6: assert property (@(posedge clk) disable iff (rst)
        cmd.capture |-> $past(cmd.update));

    // R8: done is preceded by an unload shift
    assert_done_after_unload_R8: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(cmd.shift));
endmodule

// File: rtl/hold_scan_top.sv
`timescale 1ns/1ps
module hold_scan_top
    import hscan_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [W-1:0] vec_a_i,
    input  logic [W-1:0] vec_b_i,
    output logic [W-1:0] drive_o,
    input  logic [W-1:0] resp_i,
    output logic         scan_out_o,
    output logic [W-1:0] resp_o,
    output logic         done_o
);
    chain_cmd_t   cmd;
    logic         si;
    logic [W-1:0] chain_q;

    hscan_ctrl #(.W(W)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .vec_a  (vec_a_i),
        .vec_b  (vec_b_i),
        .so_i   (scan_out_o),
        .cmd    (cmd),
        .si_o   (si),
        .resp_q (resp_o),
        .done   (done_o)
    );

    hscan_chain #(.W(W)) u_chain (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .si     (si),
        .func_d (resp_i),
        .q      (chain_q),
        .so     (scan_out_o)
    );

    hscan_hold #(.W(W)) u_hold (
        .clk (clk),
        .rst (rst),
        .upd (cmd.update),
        .d   (chain_q),
        .q   (drive_o)
    );

    logic [1:0] upd_seen;
    always_ff @(posedge clk) begin
        if (rst || done_o) begin
            upd_seen <= '0;
        end else if (cmd.update) begin
            upd_seen <= upd_seen + 1'b1;
        end
    end

    // R3: logic inputs frozen across every shift cycle
    assert_frozen_in_shift_R3: assert property (@(posedge clk) disable iff (rst)
        cmd.shift |=> $stable(drive_o));

    // R5: exactly two updates per completed run
    assert_two_updates_R5: assert property (@(posedge clk) disable iff (rst)
        done_o |-> upd_seen == 2'd2);

    // R8: done lasts a single cycle
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
endmodule

// File: tb/hold_scan_top_bench.sv
`timescale 1ns/1ps
module hold_scan_top_bench;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [W-1:0] vec_a_i = '0;
    logic [W-1:0] vec_b_i = '0;
    logic [W-1:0] drive_o;
    logic [W-1:0] resp_i;
    logic         scan_out_o;
    logic [W-1:0] resp_o;
    logic         done_o;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    bit          fault_en = 0;
    int          fault_bit = 0;
    logic [W-1:0] drive_d = '0;

    always #2 clk = ~clk;

    hold_scan_top #(.W(W)) u_hold_scan_top (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .vec_a_i    (vec_a_i),
        .vec_b_i    (vec_b_i),
        .drive_o    (drive_o),
        .resp_i     (resp_i),
        .scan_out_o (scan_out_o),
        .resp_o     (resp_o),
        .done_o     (done_o)
    );

    function automatic logic [W-1:0] logic_fn(input logic [W-1:0] x);
        return (x + 8'h5b) ^ {x[W-2:0], x[W-1]};
    endfunction

    // Logic under test, with an optional slow-to-settle output bit
    always_ff @(posedge clk) drive_d <= drive_o;
    always_comb begin
        resp_i = logic_fn(drive_o);
        if (fault_en) resp_i[fault_bit] = logic_fn(drive_d)[fault_bit];
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Cycle-by-cycle reference: model expected outputs for each edge after start
    task automatic run_pair(input logic [W-1:0] a, input logic [W-1:0] b,
                            input bit poke, input logic [W-1:0] prior_drive);
        logic [W-1:0] exp_drive;
        logic [W-1:0] exp_cap;
        exp_drive = prior_drive;
        exp_cap   = logic_fn(b);
        if (fault_en) exp_cap[fault_bit] = logic_fn(a)[fault_bit];
        @(negedge clk);
        vec_a_i = a; vec_b_i = b; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        for (int s = 1; s <= 3*W + 4; s++) begin
            if (poke && s == 5) begin
                vec_a_i = ~a; vec_b_i = a ^ 8'h0f; start_i = 1'b1;
            end
            @(posedge clk);
            if (s == W + 1)     exp_drive = a;
            if (s == 2*W + 2)   exp_drive = b;
            @(negedge clk);
            start_i = 1'b0;
            if (s <= W || (s > W + 1 && s < 2*W + 2))
                chk("R3 drive frozen while shifting", drive_o, exp_drive);
            else if (s == W + 1)
                chk("R4 first vector applied", drive_o, exp_drive);
            else if (s == 2*W + 2)
                chk("R5 second vector launched", drive_o, exp_drive);
            else
                chk(poke ? "R2 drive unaffected by busy start" : "R3 drive held", drive_o, exp_drive);
            if (s >= 2*W + 3 && s <= 3*W + 2)
                chk("R7 serial unload bit", scan_out_o, exp_cap[W-1-(s-(2*W+3))]);
            chk("R8 done timing", done_o, (s == 3*W + 3));
            if (s == 3*W + 3) begin
                chk(fault_en ? "R9 captured word under slow bit" : "R6 captured response", resp_o, exp_cap);
                if (poke) chk("R2 result from accepted vectors", resp_o, exp_cap);
            end
        end
        repeat (3) @(negedge clk);
        chk("R8 response held after done", resp_o, exp_cap);
        chk("R3 drive kept after run", drive_o, b);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] fa, fb;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 reset drive", drive_o, 0);
        chk("R1 reset scan out", scan_out_o, 0);
        chk("R1 reset done", done_o, 0);
        chk("R1 reset response", resp_o, 0);

        run_pair(8'h00, 8'hff, 0, 8'h00);
        run_pair(8'ha5, 8'ha5, 0, 8'hff);   // R5 equal words
        run_pair(8'h3c, 8'hc3, 0, 8'ha5);   // R5 complementary words
        run_pair(8'h81, 8'h7e, 1, 8'hc3);   // R2 start poked mid-run

        // R9: slow bit chosen where the two responses differ
        fa = 8'h12; fb = 8'hed;
        fault_bit = -1;
        for (int i = 0; i < W; i++)
            if (fault_bit < 0 && logic_fn(fa)[i] != logic_fn(fb)[i]) fault_bit = i;
        if (fault_bit >= 0) begin
            fault_en = 1;
            run_pair(fa, fb, 0, 8'h7e);
            compared++;
            if (resp_o === logic_fn(fb)) begin
                mismatched++;
                $display("FAIL R9 fault not observed: actual %0h expected differing from %0h",
                         resp_o, logic_fn(fb));
            end
            fault_en = 0;
            run_pair(fa, fb, 0, fb);        // R6 same pair, fault-free
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule